// File: doc/BRIEF.md
# LCD raster timing generator

The block produces horizontal sync, vertical sync and data-enable for a parallel RGB panel, and fetches pixels from an upstream source only inside the active window. Timing comes from registers written through a simple write port. The horizontal timing is a line length plus a sync width. The vertical timing is not counted in lines. A single frame counter advances once per pixel clock and wraps at a programmed frame length. The vertical sync length and the vertical display window are absolute pixel-clock counts inside that frame. Horizontal positions are counted from the start of the line's sync pulse.

The block raises a pixel request in each cycle where the position lies inside both display windows. The source answers in the same cycle with a pixel and a valid flag, and that pixel leaves on the RGB output one cycle later together with data-enable. A request the source cannot satisfy is an underflow. From then on a programmed fill color is sent instead of source data. Recovery mode returns to source data at the next frame. Without recovery the fill continues until the block is stopped. Outside the window a border color is sent. Either sync can be made active-low. Start and stop requests are applied only at a frame boundary.

Top module: `lcd_raster_gen`

## Requirements
- R1: Out of reset and whenever the block is stopped, pix_req_o and de_o are 0, rgb_o is 0, and each sync output sits at its inactive level (0 when its polarity bit is 0).
- R2: While running, a line counter runs from 0 to line length minus 1 and restarts at every frame start. hsync is active in the output cycle that follows each count below the sync width.
- R3: While running, the frame counter advances once per pixel clock from 0 to frame length minus 1 and then wraps. vsync is active in the output cycle that follows each count below the vsync length.
- R4: pix_req_o is 1 exactly in cycles where the line count lies in the inclusive horizontal window and the frame count lies in the inclusive vertical window. de_o equals pix_req_o delayed by one cycle.
- R5: While running, each requested pixel that is valid and comes with no underflow pending appears unchanged on rgb_o one cycle later. Outside the window rgb_o carries the border color.
- R6: A request answered with pix_valid_i low sends the fill color on rgb_o one cycle later: the 8-bit fill value is repeated in each of the three 8-bit channels. Every later requested pixel also gets the fill color while the underflow stays pending.
- R7: With recovery enabled, a pending underflow is cleared at the end of the frame. With recovery disabled it persists across frames and clears only when the block stops.
- R8: Polarity register bit 0 inverts hsync_o and bit 1 inverts vsync_o.
- R9: A start written while stopped takes effect on the cycle after the write is registered. A stop written while running lets the current frame finish. A start written again before that frame's end cancels the stop.
- R10: Register map (word address on wr_addr_i): 0 enable bit 0; 1 line length [11:0], sync width [27:16]; 2 frame length [23:0]; 3 vsync length [23:0]; 4 horizontal window first [11:0], last [27:16]; 5 vertical window first [23:0]; 6 vertical window last [23:0]; 7 polarity; 8 fill color [7:0], recovery enable bit 16; 9 border color [23:0]. Writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register word address |
| wr_data_i | input | DATA_W | Register write data |
| pix_i | input | 3*CH_W | Pixel from the source, answering pix_req_o |
| pix_valid_i | input | 1 | Pixel valid, sampled while pix_req_o is 1 |
| pix_req_o | output | 1 | Pixel request for the current position |
| rgb_o | output | 3*CH_W | RGB data to the panel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |

## Verification
Clean frames with every request answered show the counter wrap points, the sync widths and both window edges, because each pixel's value encodes its own position. A single missing pixel in the middle of the window is tried twice. With recovery it tells a fill that ends at the frame boundary from one that lasts only a pixel. Without recovery it tells persistent fill from fill that clears early. A stop written mid-frame, and a stop followed quickly by a start, show whether enable changes wait for the frame boundary. A restart with both polarity bits set separates inverted syncs from swapped ones.

// File: rtl/lcd_raster_pkg.sv
`timescale 1ns/1ps
package lcd_raster_pkg;
  typedef enum logic [3:0] {
    REG_ENABLE  = 4'h0,
    REG_HTIME   = 4'h1,
    REG_FLEN    = 4'h2,
    REG_VSLEN   = 4'h3,
    REG_HWIN    = 4'h4,
    REG_VWIN_LO = 4'h5,
    REG_VWIN_HI = 4'h6,
    REG_POL     = 4'h7,
    REG_FILL    = 4'h8,
    REG_BORDER  = 4'h9
  } reg_addr_e;

  localparam int unsigned HI_LSB    = 16;
  localparam int unsigned RECOV_BIT = 16;
  localparam int unsigned POL_H_BIT = 0;
  localparam int unsigned POL_V_BIT = 1;
endpackage

// File: rtl/lrg_cfg_regs.sv
`timescale 1ns/1ps
module lrg_cfg_regs
  import lcd_raster_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int H_W    = 12,
  parameter int F_W    = 24,
  parameter int CH_W   = 8,
  parameter int PIX_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              en_req_o,
  output logic [H_W-1:0]    htotal_o,
  output logic [H_W-1:0]    hs_width_o,
  output logic [F_W-1:0]    flen_o,
  output logic [F_W-1:0]    vs_len_o,
  output logic [H_W-1:0]    hwin_lo_o,
  output logic [H_W-1:0]    hwin_hi_o,
  output logic [F_W-1:0]    vwin_lo_o,
  output logic [F_W-1:0]    vwin_hi_o,
  output logic              pol_h_o,
  output logic              pol_v_o,
  output logic [CH_W-1:0]   fill_o,
  output logic              recov_o,
  output logic [PIX_W-1:0]  border_o
);
  logic unused_bits;
  assign unused_bits = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_req_o   <= 1'b0;
      htotal_o   <= '0;
      hs_width_o <= '0;
      flen_o     <= '0;
      vs_len_o   <= '0;
      hwin_lo_o  <= '0;
      hwin_hi_o  <= '0;
      vwin_lo_o  <= '0;
      vwin_hi_o  <= '0;
      pol_h_o    <= 1'b0;
      pol_v_o    <= 1'b0;
      fill_o     <= '0;
      recov_o    <= 1'b0;
      border_o   <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_W'(REG_ENABLE):  en_req_o <= wr_data_i[0];
        ADDR_W'(REG_HTIME): begin
          htotal_o   <= wr_data_i[H_W-1:0];
          hs_width_o <= wr_data_i[HI_LSB +: H_W];
        end
        ADDR_W'(REG_FLEN):    flen_o   <= wr_data_i[F_W-1:0];
        ADDR_W'(REG_VSLEN):   vs_len_o <= wr_data_i[F_W-1:0];
        ADDR_W'(REG_HWIN): begin
          hwin_lo_o <= wr_data_i[H_W-1:0];
          hwin_hi_o <= wr_data_i[HI_LSB +: H_W];
        end
        ADDR_W'(REG_VWIN_LO): vwin_lo_o <= wr_data_i[F_W-1:0];
        ADDR_W'(REG_VWIN_HI): vwin_hi_o <= wr_data_i[F_W-1:0];
        ADDR_W'(REG_POL): begin
          pol_h_o <= wr_data_i[POL_H_BIT];
          pol_v_o <= wr_data_i[POL_V_BIT];
        end
        ADDR_W'(REG_FILL): begin
          fill_o  <= wr_data_i[CH_W-1:0];
          recov_o <= wr_data_i[RECOV_BIT];
        end
        ADDR_W'(REG_BORDER):  border_o <= wr_data_i[PIX_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lrg_scan_ctr.sv
`timescale 1ns/1ps
module lrg_scan_ctr #(
  parameter int H_W = 12,
  parameter int F_W = 24
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_req_i,
  input  logic [H_W-1:0] htotal_i,
  input  logic [F_W-1:0] flen_i,
  output logic           run_o,
  output logic [H_W-1:0] h_cnt_o,
  output logic [F_W-1:0] f_cnt_o,
  output logic           at_last_o
);
  logic h_last;

  // >= keeps the counters bounded if a length shrinks while running
  assign at_last_o = (flen_i == '0) ? (f_cnt_o == '1) : (f_cnt_o >= flen_i - F_W'(1));
  assign h_last    = (htotal_i == '0) ? (h_cnt_o == '1) : (h_cnt_o >= htotal_i - H_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o   <= 1'b0;
      h_cnt_o <= '0;
      f_cnt_o <= '0;
    end else if (!run_o || at_last_o) begin
      run_o   <= en_req_i;
      h_cnt_o <= '0;
      f_cnt_o <= '0;
    end else begin
      f_cnt_o <= f_cnt_o + F_W'(1);
      h_cnt_o <= h_last ? '0 : h_cnt_o + H_W'(1);
    end
  end
endmodule

// File: rtl/lrg_range_cmp.sv
`timescale 1ns/1ps
module lrg_range_cmp #(
  parameter int W = 12
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         in_o
);
  assign in_o = (val_i >= lo_i) && (val_i <= hi_i);
endmodule

// File: rtl/lrg_window.sv
`timescale 1ns/1ps
module lrg_window #(
  parameter int H_W = 12,
  parameter int F_W = 24
) (
  input  logic           run_i,
  input  logic [H_W-1:0] h_cnt_i,
  input  logic [F_W-1:0] f_cnt_i,
  input  logic [H_W-1:0] hs_width_i,
  input  logic [F_W-1:0] vs_len_i,
  input  logic [H_W-1:0] hwin_lo_i,
  input  logic [H_W-1:0] hwin_hi_i,
  input  logic [F_W-1:0] vwin_lo_i,
  input  logic [F_W-1:0] vwin_hi_i,
  output logic           hs_act_o,
  output logic           vs_act_o,
  output logic           req_o
);
  logic h_in, v_in;

  lrg_range_cmp #(.W(H_W)) u_hcmp (
    .val_i(h_cnt_i), .lo_i(hwin_lo_i), .hi_i(hwin_hi_i), .in_o(h_in)
  );
  lrg_range_cmp #(.W(F_W)) u_vcmp (
    .val_i(f_cnt_i), .lo_i(vwin_lo_i), .hi_i(vwin_hi_i), .in_o(v_in)
  );

  assign hs_act_o = run_i && (h_cnt_i < hs_width_i);
  assign vs_act_o = run_i && (f_cnt_i < vs_len_i);
  assign req_o    = run_i && h_in && v_in;
endmodule

// File: rtl/lrg_pix_out.sv
`timescale 1ns/1ps
module lrg_pix_out #(
  parameter int PIX_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             frame_end_i,
  input  logic             hs_act_i,
  input  logic             vs_act_i,
  input  logic             req_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             pix_valid_i,
  input  logic             pol_h_i,
  input  logic             pol_v_i,
  input  logic             recov_i,
  input  logic [PIX_W-1:0] fill_i,
  input  logic [PIX_W-1:0] border_i,
  output logic [PIX_W-1:0] rgb_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o
);
  logic             uf_hold;
  logic [PIX_W-1:0] rgb_d;

  always_comb begin
    if (!run_i)                     rgb_d = '0;
    else if (!req_i)                rgb_d = border_i;
    else if (pix_valid_i && !uf_hold) rgb_d = pix_i;
    else                            rgb_d = fill_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uf_hold <= 1'b0;
      rgb_o   <= '0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
    end else begin
      rgb_o   <= rgb_d;
      hsync_o <= hs_act_i ^ pol_h_i;
      vsync_o <= vs_act_i ^ pol_v_i;
      de_o    <= req_i;
      // frame-end clear wins over an underflow on the last count
      if (!run_i)                     uf_hold <= 1'b0;
      else if (frame_end_i && recov_i) uf_hold <= 1'b0;
      else if (req_i && !pix_valid_i)  uf_hold <= 1'b1;
    end
  end
endmodule

// File: rtl/lcd_raster_gen.sv
`timescale 1ns/1ps
module lcd_raster_gen #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int H_W     = 12,
  parameter int F_W     = 24,
  parameter int CH_W    = 8,
  localparam int NCH    = 3,
  localparam int PIX_W  = NCH * CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              pix_valid_i,
  output logic              pix_req_o,
  output logic [PIX_W-1:0]  rgb_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o
);
  logic             en_req, pol_h, pol_v, recov;
  logic [H_W-1:0]   htotal, hs_width, hwin_lo, hwin_hi, h_cnt;
  logic [F_W-1:0]   fperiod, vs_len, vwin_lo, vwin_hi, f_cnt;
  logic [CH_W-1:0]  fill;
  logic [PIX_W-1:0] border, fill_rep;
  logic             run_q, at_last, hs_act, vs_act;

  assign fill_rep = {NCH{fill}};

  lrg_cfg_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .H_W(H_W), .F_W(F_W), .CH_W(CH_W), .PIX_W(PIX_W)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .en_req_o(en_req), .htotal_o(htotal), .hs_width_o(hs_width),
    .flen_o(fperiod), .vs_len_o(vs_len),
    .hwin_lo_o(hwin_lo), .hwin_hi_o(hwin_hi),
    .vwin_lo_o(vwin_lo), .vwin_hi_o(vwin_hi),
    .pol_h_o(pol_h), .pol_v_o(pol_v),
    .fill_o(fill), .recov_o(recov), .border_o(border)
  );

  lrg_scan_ctr #(.H_W(H_W), .F_W(F_W)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_req_i(en_req),
    .htotal_i(htotal), .flen_i(fperiod),
    .run_o(run_q), .h_cnt_o(h_cnt), .f_cnt_o(f_cnt), .at_last_o(at_last)
  );

  lrg_window #(.H_W(H_W), .F_W(F_W)) u_win (
    .run_i(run_q), .h_cnt_i(h_cnt), .f_cnt_i(f_cnt),
    .hs_width_i(hs_width), .vs_len_i(vs_len),
    .hwin_lo_i(hwin_lo), .hwin_hi_i(hwin_hi),
    .vwin_lo_i(vwin_lo), .vwin_hi_i(vwin_hi),
    .hs_act_o(hs_act), .vs_act_o(vs_act), .req_o(pix_req_o)
  );

  lrg_pix_out #(.PIX_W(PIX_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(run_q), .frame_end_i(run_q && at_last),
    .hs_act_i(hs_act), .vs_act_i(vs_act), .req_i(pix_req_o),
    .pix_i(pix_i), .pix_valid_i(pix_valid_i),
    .pol_h_i(pol_h), .pol_v_i(pol_v), .recov_i(recov),
    .fill_i(fill_rep), .border_i(border),
    .rgb_o(rgb_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o)
  );
endmodule

// File: rtl/lrg_checker.sv
`timescale 1ns/1ps
module lrg_checker #(
  parameter int H_W   = 12,
  parameter int F_W   = 24,
  parameter int PIX_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_q,
  input logic             at_last,
  input logic [H_W-1:0]   h_cnt,
  input logic [F_W-1:0]   f_cnt,
  input logic [H_W-1:0]   htotal,
  input logic [F_W-1:0]   fperiod,
  input logic             pix_req_o,
  input logic             pix_valid_i,
  input logic             de_o,
  input logic [PIX_W-1:0] rgb_o,
  input logic [PIX_W-1:0] fill_rep
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> (!de_o && rgb_o == '0));

  assert_line_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && htotal != '0) |-> (h_cnt < htotal));

  assert_frame_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && fperiod != '0) |-> (f_cnt < fperiod));

  assert_de_follows_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_o |=> de_o);

  assert_no_de_without_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_req_o |=> !de_o);

  assert_fill_on_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_req_o && !pix_valid_i) |=> (rgb_o == $past(fill_rep)));

  assert_stop_at_frame_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !at_last) |=> run_q);
endmodule

bind lcd_raster_gen lrg_checker #(.H_W(H_W), .F_W(F_W), .PIX_W(PIX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_q(run_q), .at_last(at_last),
  .h_cnt(h_cnt), .f_cnt(f_cnt), .htotal(htotal), .fperiod(fperiod),
  .pix_req_o(pix_req_o), .pix_valid_i(pix_valid_i), .de_o(de_o),
  .rgb_o(rgb_o), .fill_rep(fill_rep)
);

// File: tb/tb_lcd_raster_gen.sv
`timescale 1ns/1ps
module tb_lcd_raster_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [23:0] pix_i = '0;
  logic        pix_valid_i = 1'b0;
  logic        pix_req_o, hsync_o, vsync_o, de_o;
  logic [23:0] rgb_o;

  always #2.5 clk_i = ~clk_i;

  lcd_raster_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pix_i(pix_i), .pix_valid_i(pix_valid_i),
    .pix_req_o(pix_req_o), .rgb_o(rgb_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o)
  );

  typedef struct packed {
    logic        hs;
    logic        vs;
    logic        de;
    logic        req;
    logic [23:0] rgb;
    logic [7:0]  ph;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // reference model state, written from the requirements
  int c_ht = 0, c_hsw = 0, c_per = 0, c_vsl = 0, c_h0 = 0, c_h1 = 0, c_v0 = 0, c_v1 = 0;
  int c_polh = 0, c_polv = 0, c_fill = 0, c_rec = 0, c_bord = 0;
  int m_en = 0, m_run = 0, m_h = 0, m_f = 0, m_hold = 0;

  function automatic string ptag(int p);
    case (p)
      1: return "R1";   6: return "R6";   7: return "R7";
      8: return "R8";   9: return "R9";   10: return "R10";
      default: return "R5";
    endcase
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic chk(string fld, string rt, int ph, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (%s) %s at %0t: actual=%h expected=%h", rt, ptag(ph), fld, $time, act, exp);
    end
  endtask

  function automatic bit in_win(int run, int h, int f);
    return (run != 0) && h >= c_h0 && h <= c_h1 && f >= c_v0 && f <= c_v1;
  endfunction

  // driver: applies one cycle of stimulus and pushes the expected outputs
  task automatic drive(bit we, logic [3:0] a, logic [31:0] d, bit vld, int ph);
    exp_t e;
    logic [23:0] px;
    bit req, last;
    @(negedge clk_i);
    px = {8'(m_f), 8'(m_h), 8'h5A};
    wr_en_i = we; wr_addr_i = a; wr_data_i = d;
    pix_i = px; pix_valid_i = vld;
    req   = in_win(m_run, m_h, m_f);
    e.hs  = ((m_run != 0) && m_h < c_hsw) ^ c_polh[0];
    e.vs  = ((m_run != 0) && m_f < c_vsl) ^ c_polv[0];
    e.de  = req;
    if (m_run == 0)            e.rgb = '0;
    else if (!req)             e.rgb = 24'(c_bord);
    else if (vld && m_hold == 0) e.rgb = px;
    else                       e.rgb = {3{8'(c_fill)}};
    last = (m_f == c_per - 1);
    if (m_run == 0)                 m_hold = 0;
    else if (last && c_rec != 0)    m_hold = 0;
    else if (req && !vld)           m_hold = 1;
    if (m_run == 0 || last) begin
      m_run = m_en; m_h = 0; m_f = 0;
    end else begin
      m_f++;
      m_h = (m_h == c_ht - 1) ? 0 : m_h + 1;
    end
    if (we) begin
      // R10 register map
      case (a)
        4'h0: m_en = int'(d[0]);
        4'h1: begin c_ht = int'(d[11:0]); c_hsw = int'(d[27:16]); end
        4'h2: c_per = int'(d[23:0]);
        4'h3: c_vsl = int'(d[23:0]);
        4'h4: begin c_h0 = int'(d[11:0]); c_h1 = int'(d[27:16]); end
        4'h5: c_v0 = int'(d[23:0]);
        4'h6: c_v1 = int'(d[23:0]);
        4'h7: begin c_polh = int'(d[0]); c_polv = int'(d[1]); end
        4'h8: begin c_fill = int'(d[7:0]); c_rec = int'(d[16]); end
        4'h9: c_bord = int'(d[23:0]);
        default: ;
      endcase
    end
    e.req = in_win(m_run, m_h, m_f);
    e.ph  = 8'(ph);
    q.push_back(e);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, int ph);
    drive(1'b1, a, d, 1'b1, ph);
  endtask

  task automatic run(int n, int drop_f, int ph);
    for (int i = 0; i < n; i++) drive(1'b0, 4'h0, 32'h0, !(m_f == drop_f), ph);
  endtask

  // monitor: pops one expected item per cycle, 1 ns after the edge
  always @(posedge clk_i) begin
    exp_t e;
    #1;
    if (q.size() != 0) begin
      e = q.pop_front();
      chk("hsync_o",   "R2", int'(e.ph), 24'(hsync_o),   24'(e.hs));
      chk("vsync_o",   "R3", int'(e.ph), 24'(vsync_o),   24'(e.vs));
      chk("de_o",      "R4", int'(e.ph), 24'(de_o),      24'(e.de));
      chk("pix_req_o", "R4", int'(e.ph), 24'(pix_req_o), 24'(e.req));
      chk("rgb_o",     "R5", int'(e.ph), rgb_o,          e.rgb);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state
    chk("hsync_o",   "R1", 1, 24'(hsync_o),   24'h0);
    chk("vsync_o",   "R1", 1, 24'(vsync_o),   24'h0);
    chk("de_o",      "R1", 1, 24'(de_o),      24'h0);
    chk("pix_req_o", "R1", 1, 24'(pix_req_o), 24'h0);
    chk("rgb_o",     "R1", 1, rgb_o,          24'h0);
    run(2, -1, 1);
    // R10: program 10-pixel lines, 6-line frame, window h 3..8, frame counts 20..49
    wr(4'h1, 32'h0002_000A, 10);
    wr(4'h2, 32'd60, 10);
    wr(4'h3, 32'd10, 10);
    wr(4'h4, 32'h0008_0003, 10);
    wr(4'h5, 32'd20, 10);
    wr(4'h6, 32'd49, 10);
    wr(4'h7, 32'h0, 10);
    wr(4'h8, 32'h0001_00E7, 10);
    wr(4'h9, 32'h0010_2030, 10);
    run(3, -1, 1);
    // R9: start, then clean frames
    wr(4'h0, 32'h1, 9);
    run(125, -1, 5);
    // R6/R7: one missing pixel, recovery on
    run(60, 25, 6);
    run(65, -1, 7);
    // recovery off: fill persists
    wr(4'h8, 32'h0000_00C3, 7);
    run(60, 25, 6);
    run(70, -1, 7);
    // R9: stop mid-frame then start again before frame end
    run(7, -1, 9);
    wr(4'h0, 32'h0, 9);
    run(4, -1, 9);
    wr(4'h0, 32'h1, 9);
    run(70, -1, 9);
    // R9: stop, frame completes, then idle (R1)
    wr(4'h0, 32'h0, 9);
    run(75, -1, 1);
    // R8: both syncs active-low
    wr(4'h7, 32'h3, 8);
    run(3, -1, 8);
    wr(4'h0, 32'h1, 8);
    run(130, -1, 8);
    @(posedge clk_i);
    #2;
    summary();
  end
endmodule